// File: doc/BRIEF.md
# Sector Bit-Error Correction Applier

This block sits behind a multi-bit error-locator engine and repairs a 512-byte data sector in place. The engine supplies a 104-bit location word, which packs eight 13-bit bit-position fields, together with a 4-bit error count. When a start strobe arrives, the block latches both values. It walks the fields in order and recovers each position by inverting its two lowest bits. Positions that fall outside the sector are dropped. Each remaining position is flipped in the sector buffer through a byte-wide read-modify-write port.

When the walk ends, the block raises a one-cycle done pulse. It reports how many bit flips it wrote. A count code of all ones means the engine found the sector beyond repair. In that case the block leaves the buffer untouched and raises an uncorrectable flag. The sector buffer lives outside the block and answers a read one cycle after the request.

Top module: `bitfix_apply`

## Requirements
- R1: Field k of the location word (k = 0..7) is bits [13k+12 : 13k], so field 0 is the least significant 13 bits.
- R2: Each field is XORed with 3 (bit 0 and bit 1 inverted) to form the bit position that is used.
- R3: A recovered position p is applied only when p <= 4096. Applying it inverts bit p mod 8 of byte p div 8, so position 4096 lands in bit 0 of byte 512. Positions above 4096 are dropped and change no byte.
- R4: Each flip reads the byte (buf_rd_en) and, in the next cycle, writes the same address with that byte XORed by a one-hot mask (buf_wr_en). Read and write are never requested together, and there is exactly one write per applied flip.
- R5: A count code of 15 (4'hF) makes the block raise uncorrectable, issue no buffer access and report a fixed count of 0.
- R6: Fields are examined in ascending order, starting at field 0. Only the first min(count, 8) fields are examined, and a dropped field still uses up one examined slot. Counts of 9 to 14 therefore behave as 8.
- R7: fixed_cnt equals the number of positions actually applied.
- R8: done is high for exactly one cycle at the end of each job. fixed_cnt and uncorrectable keep their values until the next accepted start.
- R9: A start strobe that arrives while a job is in progress, including the cycle in which done is high, is ignored.
- R10: After reset, done, uncorrectable, fixed_cnt, buf_rd_en and buf_wr_en are all 0.
- R11: A count of 0 ends the job with done, a fixed count of 0 and no buffer access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a job when the block is idle |
| loc_word | input | 104 | Eight packed 13-bit encoded bit positions |
| err_cnt | input | 4 | Number of fields to examine; 15 = uncorrectable |
| buf_addr | output | 10 | Byte address into the sector buffer |
| buf_rd_en | output | 1 | Byte read request; data returns next cycle |
| buf_rd_data | input | 8 | Byte returned by the buffer |
| buf_wr_en | output | 1 | Byte write request |
| buf_wr_data | output | 8 | Byte value to write |
| done | output | 1 | One-cycle end-of-job pulse |
| fixed_cnt | output | 4 | Number of flips applied in the last job |
| uncorrectable | output | 1 | Last job was marked beyond repair |

## Verification
Several rules hold on every cycle, and the assertions check them there. A read and a write are never requested in the same cycle. Each write follows a read to the same address. No write happens while the uncorrectable flag is high. Done never lasts two cycles. The latched location word stays unchanged while a job runs. The addressed byte never lies beyond the last reachable byte.

Other behaviour depends on whole jobs, and only the bench scenarios can show it. These scenarios compare the repaired buffer byte for byte with a reference model. They cover the low-bit remap, dropped out-of-range positions and the exact 4096 boundary. They also cover repeated positions that cancel, counts above eight, counts of zero and fifteen, and a start strobe that arrives while a job is running.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNPACK,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } bfx_state_t;
endpackage

// File: rtl/bfx_unpack.sv
// Splits the location word into fields, restores each position and
// flags whether it lies inside the sector (R1, R2, R3).
module bfx_unpack #(
  parameter int IDX_W        = 13,
  parameter int NUM_IDX      = 8,
  parameter int SECTOR_BYTES = 512
) (
  input  logic [IDX_W*NUM_IDX-1:0]          loc_word,
  output logic [NUM_IDX-1:0][IDX_W-1:0]     idx_remap,
  output logic [NUM_IDX-1:0]                idx_ok
);
  localparam int              MAX_BIT = SECTOR_BYTES * 8;
  localparam logic [IDX_W:0]  LIMIT   = (IDX_W+1)'(MAX_BIT);
  localparam logic [IDX_W-1:0] FLIP   = IDX_W'(3);

  for (genvar g = 0; g < NUM_IDX; g++) begin : g_field
    always_comb begin
      idx_remap[g] = loc_word[g*IDX_W +: IDX_W] ^ FLIP;
      idx_ok[g]    = ({1'b0, idx_remap[g]} <= LIMIT);
    end
  end
endmodule

// File: rtl/bfx_flip.sv
// Turns one bit position into a byte address and a one-hot bit mask (R3).
module bfx_flip #(
  parameter int IDX_W  = 13,
  parameter int ADDR_W = 10
) (
  input  logic [IDX_W-1:0]  bit_idx,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [7:0]        bit_mask
);
  always_comb begin
    byte_addr = ADDR_W'(bit_idx[IDX_W-1:3]);
    bit_mask  = 8'(1) << bit_idx[2:0];
  end
endmodule

// File: rtl/bfx_seq.sv
// Job sequencer: latches the request, walks the fields, drives the
// read-modify-write port and reports the result.
module bfx_seq
  import bfx_pkg::*;
#(
  parameter int IDX_W        = 13,
  parameter int NUM_IDX      = 8,
  parameter int CNT_W        = 4,
  parameter int SECTOR_BYTES = 512,
  parameter int ADDR_W       = 10,
  parameter int FIX_W        = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [IDX_W*NUM_IDX-1:0]      loc_in,
  input  logic [CNT_W-1:0]              cnt_in,
  output logic [IDX_W*NUM_IDX-1:0]      loc_q,
  input  logic [NUM_IDX-1:0][IDX_W-1:0] idx_remap,
  input  logic [NUM_IDX-1:0]            idx_ok,
  output logic [IDX_W-1:0]              sel_idx,
  input  logic [ADDR_W-1:0]             byte_addr,
  input  logic [7:0]                    bit_mask,
  output logic [ADDR_W-1:0]             buf_addr,
  output logic                          buf_rd_en,
  input  logic [7:0]                    buf_rd_data,
  output logic                          buf_wr_en,
  output logic [7:0]                    buf_wr_data,
  output logic                          done,
  output logic [FIX_W-1:0]              fixed_cnt,
  output logic                          uncorrectable
);
  localparam int PTR_W = $clog2(NUM_IDX + 1);
  localparam int SEL_W = (NUM_IDX > 1) ? $clog2(NUM_IDX) : 1;

  bfx_state_t         state_q;
  logic [PTR_W-1:0]   ptr_q;
  logic [PTR_W-1:0]   lim_q;
  logic [SEL_W-1:0]   ptr_sel;
  logic [ADDR_W-1:0]  addr_q;
  logic [7:0]         mask_q;
  logic [FIX_W-1:0]   fix_q;
  logic               unc_q;

  assign ptr_sel = ptr_q[SEL_W-1:0];
  assign sel_idx = idx_remap[ptr_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      loc_q   <= '0;
      ptr_q   <= '0;
      lim_q   <= '0;
      addr_q  <= '0;
      mask_q  <= '0;
      fix_q   <= '0;
      unc_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            fix_q <= '0;
            ptr_q <= '0;
            loc_q <= loc_in;
            if (cnt_in == '1) begin
              unc_q   <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              unc_q <= 1'b0;
              if (int'(cnt_in) > NUM_IDX) lim_q <= PTR_W'(NUM_IDX);
              else                        lim_q <= PTR_W'(cnt_in);
              state_q <= ST_UNPACK;
            end
          end
        end
        ST_UNPACK: begin
          if (ptr_q == lim_q) begin
            state_q <= ST_DONE;
          end else if (idx_ok[ptr_sel]) begin
            addr_q  <= byte_addr;
            mask_q  <= bit_mask;
            state_q <= ST_READ;
          end else begin
            ptr_q <= ptr_q + PTR_W'(1);
          end
        end
        ST_READ:  state_q <= ST_WRITE;
        ST_WRITE: begin
          fix_q   <= fix_q + FIX_W'(1);
          ptr_q   <= ptr_q + PTR_W'(1);
          state_q <= ST_UNPACK;
        end
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign buf_addr      = addr_q;
  assign buf_rd_en     = (state_q == ST_READ);
  assign buf_wr_en     = (state_q == ST_WRITE);
  assign buf_wr_data   = buf_rd_data ^ mask_q;
  assign done          = (state_q == ST_DONE);
  assign fixed_cnt     = fix_q;
  assign uncorrectable = unc_q;

  // R4: one buffer access per cycle
  p_one_access_r4: assert property (@(posedge clk) disable iff (rst)
    !(buf_rd_en && buf_wr_en));
  // R4: a write follows a read of the same byte
  p_wr_after_rd_r4: assert property (@(posedge clk) disable iff (rst)
    buf_wr_en |-> ($past(buf_rd_en) && $stable(buf_addr)));
  // R5: an uncorrectable job never writes
  p_unc_no_wr_r5: assert property (@(posedge clk) disable iff (rst)
    uncorrectable |-> !buf_wr_en);
  // R7: the applied count cannot exceed the field count
  p_fix_bound_r7: assert property (@(posedge clk) disable iff (rst)
    int'(fixed_cnt) <= NUM_IDX);
  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9: the latched request stays put while a job runs
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> $stable(loc_q));
  // R3: no access beyond the last reachable byte
  p_addr_range_r3: assert property (@(posedge clk) disable iff (rst)
    (buf_rd_en || buf_wr_en) |-> (int'(buf_addr) <= SECTOR_BYTES));
endmodule

// File: rtl/bitfix_apply.sv
module bitfix_apply #(
  parameter int IDX_W        = 13,
  parameter int NUM_IDX      = 8,
  parameter int CNT_W        = 4,
  parameter int SECTOR_BYTES = 512,
  parameter int ADDR_W       = $clog2(SECTOR_BYTES + 1),
  parameter int FIX_W        = $clog2(NUM_IDX + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [IDX_W*NUM_IDX-1:0] loc_word,
  input  logic [CNT_W-1:0]         err_cnt,
  output logic [ADDR_W-1:0]        buf_addr,
  output logic                     buf_rd_en,
  input  logic [7:0]               buf_rd_data,
  output logic                     buf_wr_en,
  output logic [7:0]               buf_wr_data,
  output logic                     done,
  output logic [FIX_W-1:0]         fixed_cnt,
  output logic                     uncorrectable
);
  logic [IDX_W*NUM_IDX-1:0]      loc_q;
  logic [NUM_IDX-1:0][IDX_W-1:0] idx_remap;
  logic [NUM_IDX-1:0]            idx_ok;
  logic [IDX_W-1:0]              sel_idx;
  logic [ADDR_W-1:0]             byte_addr;
  logic [7:0]                    bit_mask;

  bfx_unpack #(.IDX_W(IDX_W), .NUM_IDX(NUM_IDX), .SECTOR_BYTES(SECTOR_BYTES)) u_unpack (
    .loc_word  (loc_q),
    .idx_remap (idx_remap),
    .idx_ok    (idx_ok)
  );

  bfx_flip #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_flip (
    .bit_idx   (sel_idx),
    .byte_addr (byte_addr),
    .bit_mask  (bit_mask)
  );

  bfx_seq #(
    .IDX_W(IDX_W), .NUM_IDX(NUM_IDX), .CNT_W(CNT_W),
    .SECTOR_BYTES(SECTOR_BYTES), .ADDR_W(ADDR_W), .FIX_W(FIX_W)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .loc_in        (loc_word),
    .cnt_in        (err_cnt),
    .loc_q         (loc_q),
    .idx_remap     (idx_remap),
    .idx_ok        (idx_ok),
    .sel_idx       (sel_idx),
    .byte_addr     (byte_addr),
    .bit_mask      (bit_mask),
    .buf_addr      (buf_addr),
    .buf_rd_en     (buf_rd_en),
    .buf_rd_data   (buf_rd_data),
    .buf_wr_en     (buf_wr_en),
    .buf_wr_data   (buf_wr_data),
    .done          (done),
    .fixed_cnt     (fixed_cnt),
    .uncorrectable (uncorrectable)
  );
endmodule

// File: tb/test_bitfix_apply.sv
module test_bitfix_apply;
  localparam int CLK_PERIOD = 10;
  localparam int NBYTES = 513;
  localparam int NV = 9;
  // raw bit positions per row; the bench encodes each as position ^ 3
  localparam int POS [NV][8] = '{
    '{0, 1, 2, 3, 4, 5, 6, 7},
    '{0, 1, 2, 3, 4, 5, 6, 7},
    '{1, 2, 3, 4, 5, 6, 7, 8},
    '{4096, 4095, 100, 200, 300, 400, 500, 600},
    '{5000, 12, 8191, 4097, 1, 2, 3, 4},
    '{77, 77, 5, 6, 7, 8, 9, 10},
    '{9, 300, 1000, 2000, 3000, 4000, 4090, 33},
    '{40, 41, 42, 43, 44, 45, 46, 47},
    '{10, 20, 30, 40, 50, 60, 70, 80}
  };
  localparam int CNT [NV] = '{0, 1, 8, 3, 4, 2, 11, 5, 15};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [103:0] loc_word = '0;
  logic [3:0]   err_cnt = '0;
  logic [9:0]   buf_addr;
  logic         buf_rd_en;
  logic [7:0]   buf_rd_data;
  logic         buf_wr_en;
  logic [7:0]   buf_wr_data;
  logic         done;
  logic [3:0]   fixed_cnt;
  logic         uncorrectable;

  logic [7:0] mem     [NBYTES];
  logic [7:0] ref_mem [NBYTES];
  int total = 0;
  int bad = 0;
  int wr_seen = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitfix_apply i_bitfix_apply (
    .clk(clk), .rst(rst), .start(start), .loc_word(loc_word), .err_cnt(err_cnt),
    .buf_addr(buf_addr), .buf_rd_en(buf_rd_en), .buf_rd_data(buf_rd_data),
    .buf_wr_en(buf_wr_en), .buf_wr_data(buf_wr_data), .done(done),
    .fixed_cnt(fixed_cnt), .uncorrectable(uncorrectable)
  );

  always @(posedge clk) begin
    if (buf_rd_en) buf_rd_data <= mem[buf_addr];
    if (buf_wr_en) begin
      mem[buf_addr] <= buf_wr_data;
      wr_seen = wr_seen + 1;
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill_random();
    for (int i = 0; i < NBYTES; i++) begin
      mem[i] = 8'($urandom);
      ref_mem[i] = mem[i];
    end
  endtask

  task automatic pulse_start(input logic [103:0] lw, input logic [3:0] c);
    @(negedge clk);
    loc_word = lw;
    err_cnt = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic int mem_diff();
    int d = 0;
    for (int i = 0; i < NBYTES; i++) if (mem[i] !== ref_mem[i]) d++;
    return d;
  endfunction

  initial begin
    int n;
    int applied;
    int lim;
    logic [103:0] lw;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk(done == 1'b0 && uncorrectable == 1'b0, "R10 flags", int'(done) + int'(uncorrectable), 0);
    chk(fixed_cnt == 4'd0, "R10 fixed_cnt", int'(fixed_cnt), 0);
    chk(!buf_rd_en && !buf_wr_en, "R10 access", int'(buf_rd_en) + int'(buf_wr_en), 0);

    // table walk: R1 R2 R3 R4 R5 R6 R7 R11
    for (int r = 0; r < NV; r++) begin
      fill_random();
      lw = '0;
      for (int k = 0; k < 8; k++) lw[k*13 +: 13] = 13'(POS[r][k] ^ 3);
      applied = 0;
      if (CNT[r] != 15) begin
        lim = (CNT[r] > 8) ? 8 : CNT[r];
        for (int k = 0; k < lim; k++) begin
          if (POS[r][k] <= 4096) begin
            ref_mem[POS[r][k] / 8][POS[r][k] % 8] = ~ref_mem[POS[r][k] / 8][POS[r][k] % 8];
            applied++;
          end
        end
      end
      wr_seen = 0;
      pulse_start(lw, 4'(CNT[r]));
      wait_done(n);
      chk(done == 1'b1, $sformatf("R8 done row %0d", r), int'(done), 1);
      chk(int'(fixed_cnt) == applied, $sformatf("R7/R6 count row %0d", r), int'(fixed_cnt), applied);
      chk(uncorrectable == (CNT[r] == 15), $sformatf("R5 flag row %0d", r), int'(uncorrectable), int'(CNT[r] == 15));
      @(negedge clk);
      chk(done == 1'b0, $sformatf("R8 pulse row %0d", r), int'(done), 0);
      chk(mem_diff() == 0, $sformatf("R1/R2/R3 data row %0d", r), mem_diff(), 0);
      chk(wr_seen == applied, $sformatf("R4/R11 writes row %0d", r), wr_seen, applied);
    end

    // R8: results hold after done
    repeat (4) @(negedge clk);
    chk(uncorrectable == 1'b1 && fixed_cnt == 4'd0, "R8 hold", int'(uncorrectable), 1);

    // R9: start while busy is ignored
    fill_random();
    lw = '0;
    lw[0 +: 13] = 13'(10 ^ 3);
    lw[13 +: 13] = 13'(20 ^ 3);
    ref_mem[1][2] = ~ref_mem[1][2];
    ref_mem[2][4] = ~ref_mem[2][4];
    wr_seen = 0;
    pulse_start(lw, 4'd2);
    @(negedge clk);
    loc_word = {104{1'b1}};
    err_cnt = 4'hF;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(n);
    chk(int'(fixed_cnt) == 2 && !uncorrectable, "R9 result", int'(fixed_cnt), 2);
    // R9: start during the done cycle is ignored too
    start = 1'b1;
    err_cnt = 4'hF;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(uncorrectable == 1'b0 && !done, "R9 done-cycle start", int'(uncorrectable), 0);
    chk(mem_diff() == 0 && wr_seen == 2, "R9 data", wr_seen, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule